// File: doc/BRIEF.md
# Stop/Go Majority-Clocked Keystream Generator

This block turns a 64-bit session key and a 22-bit frame vector into a run of 228 keystream bits. It does this with three short linear feedback shift registers of 19, 22 and 23 bits. After a start request, all three registers are cleared. The key and then the frame vector are then folded in one bit per enabled cycle, and every register shifts on each of those cycles. Next come 100 warm-up steps whose output is thrown away. From the warm-up onward, the registers advance irregularly. Each register exposes one clocking bit, and on every step only the registers whose clocking bit agrees with the majority of the three move.

Keystream bits leave through a valid/ready stream. A bit is transferred on a clock edge where `ks_valid` and `ks_ready` are both high. While `ks_ready` is low, the generator holds its state, so the offered bit stays unchanged until it is taken. `ks_valid` never depends on `ks_ready`. A plain clock-enable input freezes every phase while it is low, and `ks_valid` is low during that time. After the last transfer, `done` rises and stays high until the next accepted start. The key and frame vector must be held steady from the start request until the load phase has ended.

Top module: `msc_keystream_gen`

## Requirements
- R1: After reset, `ks_valid`, `done` and `ks_bit` are all 0.
- R2: A start is accepted only in a cycle where `en` is high and the block is idle or done. An accepted start clears all three registers. Over the next 86 enabled cycles, all three registers shift every cycle. On these cycles key bits 0..63 and then frame-vector bits 0..21, least significant first, are XORed into the bit that enters at position 0.
- R3: A register that advances shifts left by one. The XOR of its taps enters at bit 0. The taps are bits 18,17,16,13 of the 19-bit register, bits 21,20 of the 22-bit register, and bits 22,21,20,7 of the 23-bit register.
- R4: In warm-up and output, the clocking bits are bit 8, bit 10 and bit 10 of the three registers. A register advances only when its clocking bit equals the majority of the three, so two or three registers move on each step. All four movement patterns occur: all three move, or exactly one of the three stays.
- R5: Warm-up lasts 100 enabled steps, during which `ks_valid` stays low. With `en` held high, `ks_valid` first rises 186 clock edges after the accepting edge.
- R6: Each output bit is the XOR of bit 18, bit 21 and bit 22 of the three registers after that step's majority advance. Exactly 228 bits are transferred per start.
- R7: The state advances in the output phase only on a transfer. While `ks_valid` is high and `ks_ready` is low, `ks_bit` holds its value.
- R8: `ks_valid` is high only in the output phase and only while `en` is high. `ks_bit` is 0 whenever `ks_valid` is low.
- R9: `done` rises on the edge after the 228th transfer and stays high until an accepted start. A start during load, warm-up or output is ignored.
- R10: While `en` is low, no register, counter or phase changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a new keystream run |
| en | input | 1 | Clock enable; low freezes the block |
| key | input | 64 | Session key, bit 0 applied first |
| iv | input | 22 | Frame vector, bit 0 applied first after the key |
| ks_ready | input | 1 | Consumer accepts the offered bit |
| ks_bit | output | 1 | Offered keystream bit |
| ks_valid | output | 1 | `ks_bit` is valid |
| done | output | 1 | All 228 bits have been transferred |

## Verification
The bound checker checks several rules on every cycle. Every majority step moves at least two registers. The offered bit holds while the consumer stalls. `ks_valid` is never high without `en` or after `done`. `done` persists until a start. The total state is frozen whenever `en` is low. The transfer count equals 228 when `done` rises.

The tap positions, the key and frame-vector bit order, and the 186-edge latency to the first bit are only visible through end-to-end stream comparison. The scenarios compare every transferred bit against a bit-serial reference model under full throughput, random back-pressure and random enable gaps. They also cover an all-zero and an all-one key, and a start pulse issued in mid-run.

// File: rtl/msc_pkg.sv
package msc_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LOAD,
    PH_WARM,
    PH_OUT,
    PH_DONE
  } phase_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/msc_lfsr.sv
module msc_lfsr #(
  parameter int unsigned LEN = 19,
  parameter logic [LEN-1:0] TAPS = '0,
  parameter int unsigned CB = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           adv,
  input  logic           inj,
  output logic [LEN-1:0] state,
  output logic           cbit,
  output logic           msb_now,
  output logic           msb_moved
);

  logic fb;

  // feedback: parity of the tapped bits, plus the injected load bit
  assign fb = (^(state & TAPS)) ^ inj;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= '0;
    end else if (clr) begin
      state <= '0;
    end else if (adv) begin
      state <= {state[LEN-2:0], fb};
    end
  end

  assign cbit      = state[CB];
  assign msb_now   = state[LEN-1];
  assign msb_moved = state[LEN-2];

endmodule

// File: rtl/msc_vote.sv
module msc_vote #(
  parameter int unsigned N = 3
) (
  input  logic [N-1:0] cb,
  output logic [N-1:0] move
);

  logic m;

  assign m = msc_pkg::maj3(cb[0], cb[1], cb[2]);

  for (genvar i = 0; i < N; i++) begin : g_agree
    assign move[i] = ~(cb[i] ^ m);
  end

endmodule

// File: rtl/msc_seq.sv
module msc_seq #(
  parameter int unsigned LOAD_N = 86,
  parameter int unsigned WARM_N = 100,
  parameter int unsigned OUT_N  = 228,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned LD_W   = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                start,
  input  logic                fire,
  output msc_pkg::phase_e     phase,
  output logic                accept,
  output logic [LD_W-1:0]     ld_idx
);

  import msc_pkg::*;

  logic [CNT_W-1:0] cnt;

  assign accept = en && start && (phase == PH_IDLE || phase == PH_DONE);
  assign ld_idx = cnt[LD_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      unique case (phase)
        PH_IDLE, PH_DONE: begin
          if (accept) begin
            phase <= PH_LOAD;
            cnt   <= '0;
          end
        end
        PH_LOAD: begin
          if (en) begin
            if (cnt == CNT_W'(LOAD_N - 1)) begin
              phase <= PH_WARM;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        PH_WARM: begin
          if (en) begin
            if (cnt == CNT_W'(WARM_N - 1)) begin
              phase <= PH_OUT;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        PH_OUT: begin
          if (fire) begin
            if (cnt == CNT_W'(OUT_N - 1)) begin
              phase <= PH_DONE;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: begin
          phase <= PH_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/msc_keystream_gen.sv
module msc_keystream_gen #(
  parameter int unsigned KEY_W  = 64,
  parameter int unsigned IV_W   = 22,
  parameter int unsigned WARM_N = 100,
  parameter int unsigned OUT_N  = 228,
  parameter int unsigned L1     = 19,
  parameter int unsigned L2     = 22,
  parameter int unsigned L3     = 23,
  parameter logic [L1-1:0] TAP1 = 19'h72000,
  parameter logic [L2-1:0] TAP2 = 22'h300000,
  parameter logic [L3-1:0] TAP3 = 23'h700080,
  parameter int unsigned CB1    = 8,
  parameter int unsigned CB2    = 10,
  parameter int unsigned CB3    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             en,
  input  logic [KEY_W-1:0] key,
  input  logic [IV_W-1:0]  iv,
  input  logic             ks_ready,
  output logic             ks_bit,
  output logic             ks_valid,
  output logic             done
);

  import msc_pkg::*;

  localparam int unsigned LOAD_N = KEY_W + IV_W;
  localparam int unsigned LD_W   = $clog2(LOAD_N);
  localparam int unsigned MAX_A  = (LOAD_N > WARM_N) ? LOAD_N : WARM_N;
  localparam int unsigned MAX_N  = (MAX_A > OUT_N) ? MAX_A : OUT_N;
  localparam int unsigned CNT_W  = $clog2(MAX_N);

  phase_e          phase;
  logic            accept;
  logic [LD_W-1:0] ld_idx;
  logic            ph_load, ph_warm, ph_out;
  logic            fire;
  logic            ld_bit;
  logic [LOAD_N-1:0] load_vec;
  logic [2:0]      cb, move, adv, now_msb, moved_msb, out_msb;
  logic            inj;

  logic [L1-1:0] s1;
  logic [L2-1:0] s2;
  logic [L3-1:0] s3;

  msc_seq #(
    .LOAD_N(LOAD_N), .WARM_N(WARM_N), .OUT_N(OUT_N),
    .CNT_W(CNT_W), .LD_W(LD_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .start(start), .fire(fire),
    .phase(phase), .accept(accept), .ld_idx(ld_idx)
  );

  assign ph_load = (phase == PH_LOAD);
  assign ph_warm = (phase == PH_WARM);
  assign ph_out  = (phase == PH_OUT);

  // key first, least significant bit first, then the frame vector
  assign load_vec = {iv, key};
  assign ld_bit   = load_vec[ld_idx];
  assign inj      = ph_load & ld_bit;

  msc_vote #(.N(3)) u_vote (.cb(cb), .move(move));

  always_comb begin
    if (ph_load && en)            adv = 3'b111;
    else if ((ph_warm && en) || fire) adv = move;
    else                          adv = 3'b000;
  end

  msc_lfsr #(.LEN(L1), .TAPS(TAP1), .CB(CB1)) u_r1 (
    .clk(clk), .rst_n(rst_n), .clr(accept), .adv(adv[0]), .inj(inj),
    .state(s1), .cbit(cb[0]), .msb_now(now_msb[0]), .msb_moved(moved_msb[0])
  );

  msc_lfsr #(.LEN(L2), .TAPS(TAP2), .CB(CB2)) u_r2 (
    .clk(clk), .rst_n(rst_n), .clr(accept), .adv(adv[1]), .inj(inj),
    .state(s2), .cbit(cb[1]), .msb_now(now_msb[1]), .msb_moved(moved_msb[1])
  );

  msc_lfsr #(.LEN(L3), .TAPS(TAP3), .CB(CB3)) u_r3 (
    .clk(clk), .rst_n(rst_n), .clr(accept), .adv(adv[2]), .inj(inj),
    .state(s3), .cbit(cb[2]), .msb_now(now_msb[2]), .msb_moved(moved_msb[2])
  );

  // offered bit reflects the state after this step's majority advance
  for (genvar i = 0; i < 3; i++) begin : g_msb
    assign out_msb[i] = move[i] ? moved_msb[i] : now_msb[i];
  end

  assign ks_valid = ph_out & en;
  assign fire     = ks_valid & ks_ready;
  assign ks_bit   = ks_valid & (^out_msb);
  assign done     = (phase == PH_DONE);

endmodule

// File: rtl/msc_keystream_chk.sv
module msc_keystream_chk #(
  parameter int unsigned OUT_N = 228,
  parameter int unsigned ST_W  = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            en,
  input logic            ks_ready,
  input logic            ks_valid,
  input logic            ks_bit,
  input logic            done,
  input logic            ph_load,
  input logic            ph_warm,
  input logic            ph_out,
  input logic [2:0]      adv,
  input logic [ST_W-1:0] st
);

  localparam int unsigned CW = $clog2(OUT_N + 1);

  logic [CW-1:0] xfers;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   xfers <= '0;
    else if (ph_load)             xfers <= '0;
    else if (ks_valid && ks_ready) xfers <= xfers + 1'b1;
  end

  // R4
  majority_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph_warm || ph_out) && adv != 3'b000) |-> ($countones(adv) >= 2));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ks_valid && !ks_ready) |=> (!ks_valid || $stable(ks_bit)));

  // R8
  valid_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ks_valid |-> (en && !done));

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(start && en)) |=> done);

  // R6
  done_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (xfers == CW'(OUT_N)));

  // R10
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(st));

endmodule

bind msc_keystream_gen msc_keystream_chk #(
  .OUT_N(OUT_N), .ST_W(L1 + L2 + L3)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .en(en), .ks_ready(ks_ready),
  .ks_valid(ks_valid), .ks_bit(ks_bit), .done(done),
  .ph_load(ph_load), .ph_warm(ph_warm), .ph_out(ph_out),
  .adv(adv), .st({s1, s2, s3})
);

// File: tb/msc_keystream_gen_tb.sv
module msc_keystream_gen_tb;

  localparam int OUT_N = 228;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        en = 1'b0;
  logic        ks_ready = 1'b0;
  logic [63:0] key = '0;
  logic [21:0] iv = '0;
  logic        ks_bit, ks_valid, done;

  int  checks = 0;
  int  errors = 0;
  int  mode = 0;
  int  fires = 0;
  int  pat_seen[4] = '{0, 0, 0, 0};
  bit  exp_q[$];
  bit  prev_stall = 1'b0;
  bit  prev_bit = 1'b0;
  bit  finished = 1'b0;

  msc_keystream_gen u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .en(en), .key(key), .iv(iv),
    .ks_ready(ks_ready), .ks_bit(ks_bit), .ks_valid(ks_valid), .done(done)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bit-serial reference model: pushes the expected stream into the queue
  task automatic ref_push(input logic [63:0] k, input logic [21:0] v);
    logic [18:0] a = '0;
    logic [21:0] b = '0;
    logic [22:0] c = '0;
    for (int i = 0; i < 86; i++) begin
      logic x;
      x = (i < 64) ? k[i] : v[i-64];
      a = {a[17:0], a[18] ^ a[17] ^ a[16] ^ a[13] ^ x};
      b = {b[20:0], b[21] ^ b[20] ^ x};
      c = {c[21:0], c[22] ^ c[21] ^ c[20] ^ c[7] ^ x};
    end
    for (int i = 0; i < 100 + OUT_N; i++) begin
      logic m, ma, mb, mc;
      m  = (a[8] & b[10]) | (a[8] & c[10]) | (b[10] & c[10]);
      ma = (a[8] == m);
      mb = (b[10] == m);
      mc = (c[10] == m);
      if (ma && mb && mc) pat_seen[0]++;
      else if (!ma)       pat_seen[1]++;
      else if (!mb)       pat_seen[2]++;
      else                pat_seen[3]++;
      if (ma) a = {a[17:0], a[18] ^ a[17] ^ a[16] ^ a[13]};
      if (mb) b = {b[20:0], b[21] ^ b[20]};
      if (mc) c = {c[21:0], c[22] ^ c[21] ^ c[20] ^ c[7]};
      if (i >= 100) exp_q.push_back(a[18] ^ b[21] ^ c[22]);
    end
  endtask

  // monitor: owns en/ready, pops the scoreboard on every transfer
  always @(negedge clk) begin
    if (rst_n) begin
      case (mode)
        0: begin en = 1'b1; ks_ready = 1'b1; end
        1: begin en = 1'b1; ks_ready = (($urandom % 3) != 0); end
        default: begin en = (($urandom % 4) != 0); ks_ready = (($urandom % 2) != 0); end
      endcase
      #1;
      if (ks_valid) begin
        chk(en, "R8 valid only with enable", int'(en), 1);
        if (prev_stall) chk(ks_bit == prev_bit, "R7 bit held under stall", int'(ks_bit), int'(prev_bit));
      end
      prev_stall = ks_valid && !ks_ready;
      prev_bit   = ks_bit;
      if (ks_valid && ks_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6 transfer beyond expected stream", fires, OUT_N);
        end else begin
          bit e;
          e = exp_q.pop_front();
          // R2/R3 load and taps, R4 vote, R6 output; mode 2 covers R10
          chk(ks_bit == e, (mode == 2) ? "R10 R6 stream under enable gaps" : "R6 stream bit (R2/R3/R4)",
              int'(ks_bit), int'(e));
        end
        fires++;
      end
    end
  end

  task automatic run_test(input logic [63:0] k, input logic [21:0] v, input int md, input bit timed);
    int n;
    mode = md;
    key  = k;
    iv   = v;
    ref_push(k, v);
    fires = 0;
    @(negedge clk);
    start = 1'b1;
    do @(posedge clk); while (!en);
    @(negedge clk);
    start = 1'b0;
    #2;
    chk(!done, "R9 done cleared by accepted start", int'(done), 0);
    if (timed) begin
      n = 0;
      forever begin
        @(posedge clk);
        @(negedge clk);
        start = (n == 119);  // start during warm-up must be ignored (R9)
        #2;
        n++;
        if (ks_valid) break;
        if (n > 400) break;
      end
      start = 1'b0;
      chk(n == 186, "R5 edges to first valid", n, 186);
    end
    while (fires < OUT_N) @(posedge clk);
    @(negedge clk);
    #2;
    chk(done, "R9 done after last transfer", int'(done), 1);
    chk(!ks_valid, "R8 no valid after done", int'(ks_valid), 0);
    chk(exp_q.size() == 0, "R6 exactly 228 transfers", exp_q.size(), 0);
    repeat (5) @(negedge clk);
    #2;
    chk(done, "R9 done holds while idle", int'(done), 1);
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #2;
    chk(!ks_valid, "R1 reset valid", int'(ks_valid), 0);
    chk(!done, "R1 reset done", int'(done), 0);
    chk(!ks_bit, "R1 reset bit", int'(ks_bit), 0);
    rst_n = 1'b1;

    run_test(64'h0123_4567_89AB_CDEF, 22'h3A5C1, 0, 1'b1);
    run_test(64'hFEDC_BA98_7654_3210, 22'h00134, 1, 1'b0);  // R7 back-pressure
    run_test(64'hDEAD_BEEF_0BAD_F00D, 22'h2AAAA, 2, 1'b0);  // R10 enable gaps
    run_test(64'h0, 22'h0, 0, 1'b1);                        // all-zero state
    run_test(64'hFFFF_FFFF_FFFF_FFFF, 22'h3FFFFF, 1, 1'b0);

    // R4: every movement pattern was exercised by the stimulus
    for (int p = 0; p < 4; p++) chk(pat_seen[p] > 0, "R4 movement pattern seen", pat_seen[p], 1);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule